// File: doc/BRIEF.md
# Previous-Plane Sample Pairing Stage

This block sits at the head of a spectral-cube compressor. Samples of a cube arrive one at a time in band-interleaved-by-line order, so each horizontal plane (one image row across every band and column) streams in as a contiguous run. For every incoming sample the block writes it into a store that holds exactly one plane, and in the same cycle reads back what that store location held: the sample at the same band and column one row earlier. It then presents both values together to a downstream predictor.

The plane length is set at run time as columns times bands. A position counter walks through the plane, wraps at the last position and moves on to the next plane, with no limit on how many planes a cube has. While the first plane of a cube is streaming there is no earlier row, so the earlier-row half of each pair is replaced by zero. A one-cycle cube restart pulse returns the block to position zero and marks the next plane as the first plane again. Input and output both use valid/ready handshakes, and a stalled consumer freezes the store and the counter so no sample is lost.

Top module: `plane_pair_grabber`

## Requirements
- R1: Every accepted input sample appears on `pair_cur` exactly once, in the order it was accepted.
- R2: For a sample at plane position k of any plane after the first, `pair_prev` equals the sample accepted at position k of the plane before it (the store returns the old content of a location that is written in the same cycle).
- R3: For every sample of the first plane of a cube, `pair_prev` is 16'h0000 and `pair_first` is 1; for later planes `pair_first` is 0.
- R4: Plane position counts accepted samples from 0 to `cfg_cols*cfg_bands-1`; `pair_sop` is 1 exactly at position 0, `pair_eop` exactly at the last position, and the sample after the last position is position 0 of the next plane.
- R5: A one-cycle `cube_start` pulse, even in the middle of a plane, makes the next accepted sample position 0 of a first plane.
- R6: While `pair_valid` is 1 and `pair_ready` is 0, all pair outputs hold their values and `pair_valid` stays 1.
- R7: `smp_ready` is 1 whenever the output register is empty or `pair_ready` is 1, and 0 otherwise.
- R8: The plane length follows `cfg_cols` and `cfg_bands`, from a single sample up to `MAX_COLS*MAX_BANDS`, and any number of planes per cube is handled.
- R9: After reset `pair_valid` is 0 and `smp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | $clog2(MAX_COLS+1) | Columns per row, 1 to MAX_COLS |
| cfg_bands | input | $clog2(MAX_BANDS+1) | Bands per row, 1 to MAX_BANDS |
| cube_start | input | 1 | One-cycle pulse that begins a new cube |
| smp_valid | input | 1 | Input sample is offered |
| smp_ready | output | 1 | Block takes the offered sample this cycle |
| smp_data | input | 16 | Input sample |
| pair_valid | output | 1 | Output pair is present |
| pair_ready | input | 1 | Consumer takes the pair this cycle |
| pair_cur | output | 16 | Current-plane sample |
| pair_prev | output | 16 | Same-position sample from the previous plane, or zero in the first plane |
| pair_first | output | 1 | Pair belongs to the first plane of the cube |
| pair_sop | output | 1 | Pair is at plane position 0 |
| pair_eop | output | 1 | Pair is at the last plane position |

## Verification
The assertions take for granted that `cfg_cols` and `cfg_bands` are nonzero and change only while no sample is being accepted just before a `cube_start` pulse, and that `cube_start` is never raised in a cycle that also accepts a sample. The bench keeps to this by draining all output pairs, lowering `smp_valid`, setting the new configuration and only then pulsing `cube_start` for one cycle. Sample values encode cube, plane and position arithmetically, so the expected previous-row value is recomputed rather than remembered, and a stale value left over from an earlier cube or an aborted plane differs from zero.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int unsigned SMP_W = 16;

    typedef logic [SMP_W-1:0] smp_t;

    localparam smp_t SMP_ZERO = '0;

endpackage

// File: rtl/ppg_line_store.sv
module ppg_line_store #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic [AW-1:0]        addr,
    input  ppg_pkg::smp_t        wdata,
    output ppg_pkg::smp_t        rdata
);

    ppg_pkg::smp_t mem_q [DEPTH];
    ppg_pkg::smp_t rdata_q;

    // Read and write share one address; the read takes the content
    // from before this cycle's write.
    always_ff @(posedge clk) begin
        if (en) begin
            rdata_q     <= mem_q[addr];
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ppg_addr_seq.sv
module ppg_addr_seq #(
    parameter int unsigned MAX_COLS  = 8,
    parameter int unsigned MAX_BANDS = 8,
    localparam int unsigned DEPTH    = MAX_COLS * MAX_BANDS,
    localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW       = $clog2(DEPTH + 1),
    localparam int unsigned CW       = $clog2(MAX_COLS + 1),
    localparam int unsigned BW       = $clog2(MAX_BANDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_cols,
    input  logic [BW-1:0] cfg_bands,
    input  logic          cube_start,
    input  logic          accept,
    output logic [AW-1:0] cur_addr,
    output logic          cur_first,
    output logic          cur_sop,
    output logic          cur_eop
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          first;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [LW-1:0] plane_len;
    logic [LW-1:0] last_pos;
    logic [AW-1:0] eff_addr;
    logic          eff_first;
    logic          at_last;

    always_comb begin
        plane_len = LW'(cfg_cols) * LW'(cfg_bands);
        last_pos  = plane_len - LW'(1);
        eff_addr  = cube_start ? '0   : seq_q.addr;
        eff_first = cube_start ? 1'b1 : seq_q.first;
        at_last   = (LW'(eff_addr) == last_pos);

        seq_d.addr  = eff_addr;
        seq_d.first = eff_first;
        if (accept) begin
            if (at_last) begin
                seq_d.addr  = '0;
                seq_d.first = 1'b0;
            end else begin
                seq_d.addr  = eff_addr + AW'(1);
            end
        end

        cur_addr  = eff_addr;
        cur_first = eff_first;
        cur_sop   = (eff_addr == '0);
        cur_eop   = at_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.addr  <= '0;
            seq_q.first <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cur_eop |=> seq_q.addr == '0);

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cur_eop |=> seq_q.addr == $past(cur_addr) + AW'(1));

    // R3
    first_ends_at_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.first) |-> $past(accept && cur_eop));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cube_start && !accept |=> seq_q.first && seq_q.addr == '0);

endmodule

// File: rtl/ppg_pair_stage.sv
module ppg_pair_stage (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    output logic          smp_ready,
    input  ppg_pkg::smp_t smp_data,
    input  logic          cur_first,
    input  logic          cur_sop,
    input  logic          cur_eop,
    input  ppg_pkg::smp_t store_rdata,
    output logic          accept,
    output logic          pair_valid,
    input  logic          pair_ready,
    output ppg_pkg::smp_t pair_cur,
    output ppg_pkg::smp_t pair_prev,
    output logic          pair_first,
    output logic          pair_sop,
    output logic          pair_eop
);

    typedef struct packed {
        logic          valid;
        ppg_pkg::smp_t cur;
        logic          first;
        logic          sop;
        logic          eop;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        smp_ready = !slot_q.valid || pair_ready;
        accept    = smp_valid && smp_ready;

        slot_d = slot_q;
        if (accept) begin
            slot_d.valid = 1'b1;
            slot_d.cur   = smp_data;
            slot_d.first = cur_first;
            slot_d.sop   = cur_sop;
            slot_d.eop   = cur_eop;
        end else if (pair_ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pair_valid = slot_q.valid;
    assign pair_cur   = slot_q.cur;
    assign pair_prev  = slot_q.first ? ppg_pkg::SMP_ZERO : store_rdata;
    assign pair_first = slot_q.first;
    assign pair_sop   = slot_q.sop;
    assign pair_eop   = slot_q.eop;

    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid && !pair_ready |=> pair_valid && $stable(pair_cur)
            && $stable(pair_prev) && $stable(pair_first)
            && $stable(pair_sop) && $stable(pair_eop));

    // R1
    load_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pair_valid && pair_cur == $past(smp_data));

endmodule

// File: rtl/plane_pair_grabber.sv
module plane_pair_grabber #(
    parameter int unsigned MAX_COLS  = 8,
    parameter int unsigned MAX_BANDS = 8,
    localparam int unsigned DEPTH    = MAX_COLS * MAX_BANDS,
    localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW       = $clog2(MAX_COLS + 1),
    localparam int unsigned BW       = $clog2(MAX_BANDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_cols,
    input  logic [BW-1:0] cfg_bands,
    input  logic          cube_start,
    input  logic          smp_valid,
    output logic          smp_ready,
    input  logic [15:0]   smp_data,
    output logic          pair_valid,
    input  logic          pair_ready,
    output logic [15:0]   pair_cur,
    output logic [15:0]   pair_prev,
    output logic          pair_first,
    output logic          pair_sop,
    output logic          pair_eop
);

    logic          accept;
    logic [AW-1:0] cur_addr;
    logic          cur_first;
    logic          cur_sop;
    logic          cur_eop;
    ppg_pkg::smp_t store_rdata;

    ppg_addr_seq #(
        .MAX_COLS  (MAX_COLS),
        .MAX_BANDS (MAX_BANDS)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_cols   (cfg_cols),
        .cfg_bands  (cfg_bands),
        .cube_start (cube_start),
        .accept     (accept),
        .cur_addr   (cur_addr),
        .cur_first  (cur_first),
        .cur_sop    (cur_sop),
        .cur_eop    (cur_eop)
    );

    ppg_line_store #(
        .DEPTH (DEPTH)
    ) store_i (
        .clk   (clk),
        .en    (accept),
        .addr  (cur_addr),
        .wdata (smp_data),
        .rdata (store_rdata)
    );

    ppg_pair_stage stage_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_ready   (smp_ready),
        .smp_data    (smp_data),
        .cur_first   (cur_first),
        .cur_sop     (cur_sop),
        .cur_eop     (cur_eop),
        .store_rdata (store_rdata),
        .accept      (accept),
        .pair_valid  (pair_valid),
        .pair_ready  (pair_ready),
        .pair_cur    (pair_cur),
        .pair_prev   (pair_prev),
        .pair_first  (pair_first),
        .pair_sop    (pair_sop),
        .pair_eop    (pair_eop)
    );

    // R7
    ready_when_draining_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |-> smp_ready);

endmodule

// File: tb/plane_pair_grabber_tb.sv
module plane_pair_grabber_tb_top;

    localparam int MAX_COLS  = 8;
    localparam int MAX_BANDS = 8;
    localparam int CW = $clog2(MAX_COLS + 1);
    localparam int BW = $clog2(MAX_BANDS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_cols = CW'(1);
    logic [BW-1:0] cfg_bands = BW'(1);
    logic          cube_start = 1'b0;
    logic          smp_valid = 1'b0;
    logic          smp_ready;
    logic [15:0]   smp_data = '0;
    logic          pair_valid;
    logic          pair_ready = 1'b0;
    logic [15:0]   pair_cur;
    logic [15:0]   pair_prev;
    logic          pair_first;
    logic          pair_sop;
    logic          pair_eop;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    plane_pair_grabber #(
        .MAX_COLS  (MAX_COLS),
        .MAX_BANDS (MAX_BANDS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_cols   (cfg_cols),
        .cfg_bands  (cfg_bands),
        .cube_start (cube_start),
        .smp_valid  (smp_valid),
        .smp_ready  (smp_ready),
        .smp_data   (smp_data),
        .pair_valid (pair_valid),
        .pair_ready (pair_ready),
        .pair_cur   (pair_cur),
        .pair_prev  (pair_prev),
        .pair_first (pair_first),
        .pair_sop   (pair_sop),
        .pair_eop   (pair_eop)
    );

    function automatic logic [15:0] samp(int cid, int plane, int pos);
        return {cid[3:0], plane[3:0], pos[7:0]} ^ 16'h0A5A;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic run_cube(int cid, int cols, int bands, int total,
                            bit rnd_in, bit rnd_out);
        int len  = cols * bands;
        int prod = 0;
        int cons = 0;
        bit held = 1'b0;
        logic [15:0] h_cur, h_prev;
        logic h_first, h_sop, h_eop;

        @(negedge clk);
        smp_valid  = 1'b0;
        pair_ready = 1'b1;
        cfg_cols   = CW'(cols);
        cfg_bands  = BW'(bands);
        cube_start = 1'b1;
        @(negedge clk);
        cube_start = 1'b0;

        while (cons < total) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            smp_valid  = (prod < total) && (!rnd_in || lfsr[0] || lfsr[5]);
            smp_data   = samp(cid, prod / len, prod % len);
            pair_ready = !rnd_out || lfsr[3] || lfsr[9];
            #1;
            // R7: ready rule observed at the ports
            chk(smp_ready == (!pair_valid || pair_ready), "R7",
                smp_ready, !pair_valid || pair_ready);
            if (held) begin
                // R6: stalled pair must not change
                chk(pair_valid && pair_cur == h_cur && pair_prev == h_prev
                    && pair_first == h_first && pair_sop == h_sop
                    && pair_eop == h_eop, "R6", pair_cur, h_cur);
            end
            held    = pair_valid && !pair_ready;
            h_cur   = pair_cur;
            h_prev  = pair_prev;
            h_first = pair_first;
            h_sop   = pair_sop;
            h_eop   = pair_eop;
            if (pair_valid && pair_ready) begin
                int pl = cons / len;
                int ps = cons % len;
                logic [15:0] e_prev = (pl == 0) ? 16'h0000 : samp(cid, pl - 1, ps);
                chk(pair_cur == samp(cid, pl, ps), "R1", pair_cur, samp(cid, pl, ps));
                if (pl == 0)
                    chk(pair_prev == 16'h0000 && pair_first, "R3", pair_prev, 0);
                else
                    chk(pair_prev == e_prev && !pair_first, "R2", pair_prev, e_prev);
                chk(pair_sop == (ps == 0), "R4 sop", pair_sop, ps == 0);
                chk(pair_eop == (ps == len - 1), "R4 eop", pair_eop, ps == len - 1);
                cons++;
            end
            if (smp_valid && smp_ready) prod++;
            @(negedge clk);
        end
        smp_valid  = 1'b0;
        pair_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state, consumer not ready
        chk(!pair_valid, "R9 valid", pair_valid, 0);
        chk(smp_ready, "R9 ready", smp_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!pair_valid && smp_ready, "R9 after release", pair_valid, 0);

        run_cube(1, 3, 2, 4 * 6, 1'b0, 1'b0);      // R1 R2 R3 R4 full rate
        run_cube(2, 8, 8, 3 * 64, 1'b1, 1'b1);     // R8 largest plane, R6 stalls
        run_cube(3, 1, 1, 6, 1'b1, 1'b0);          // R8 single-sample plane
        run_cube(4, 5, 3, 2 * 15 + 4, 1'b0, 1'b1); // aborted mid-plane
        run_cube(5, 2, 4, 5 * 8, 1'b1, 1'b1);      // R5 restart after abort
        run_cube(6, 5, 3, 3 * 15, 1'b1, 1'b1);     // R5 stale data must not leak

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule